// File: doc/BRIEF.md
# Timer Bank Control Hub

This block sits beside a bank of countdown timer channels and holds everything the channels share. It keeps one run-enable bit per channel, which software changes only through a set-strobe address and a clear-strobe address. It keeps a sticky timeout flag per channel that software clears by writing ones, an interrupt mask, and one combined interrupt line. The counting logic itself lives in the channels. The hub only receives their timeout pulses and sends back enables, a run/freeze level, a soft-reset level and one trigger per channel.

Each channel's trigger comes from one of two places. Its source bit picks either a dedicated external trigger line or an internal trigger. For the internal trigger, a 4-bit selector picks the timeout pulse of any channel in the bank. A soft-reset bit in the control word keeps every other register at zero for as long as it is set. The control word itself keeps its value. Two further control bits let the channels keep running while the debug or low-power doze inputs are high. Register access uses a single-cycle write strobe and a combinational read strobe.

Top module: `timer_ctrl_hub`

## Requirements
- R1: A write to address 3 sets every channel-enable bit whose write-data bit is one. Zero bits leave their enable unchanged. Enables appear on `chan_en_o` after the write edge.
- R2: A write to address 4 clears every channel-enable bit whose write-data bit is one. Zero bits leave their enable unchanged.
- R3: A one on `tmo_i[i]` at a clock edge sets flag i. Flags read at address 1, bit i. Writing a one to a flag bit clears it, and writing a zero leaves it unchanged.
- R4: When a timeout and a write-one-to-clear reach the same flag at the same edge, the flag stays set.
- R5: The interrupt mask is written and read at address 2, with bit i belonging to channel i. `irq_o` is high exactly when some flag and its mask bit are both one.
- R6: The control word at address 0 has bit 0 run-in-debug, bit 1 run-in-doze and bit 2 soft reset. While bit 2 is one, `chan_rst_o` is high, and enables, flags, mask and trigger configurations are held at zero. Writes to them and timeouts are ignored, and the control word keeps its value.
- R7: Trigger configuration for channel i is at address 8+i, with bits 3:0 the selector and bit 8 the source. With source 0, `trig_o[i]` follows `ext_trig_i[i]`. With source 1, it follows `tmo_i[selector]`.
- R8: An internal trigger whose selector names a channel at or above the channel count is constant zero.
- R9: `chan_run_o` is low when `dbg_i` is high and run-in-debug is zero, or when `doze_i` is high and run-in-doze is zero. Otherwise it is high.
- R10: After reset, every register reads zero, `irq_o` and `chan_rst_o` are low, and `chan_en_o` is zero.
- R11: Reads return data only while `rd_en` is high. Address 3 returns the current enable bits. Address 4 and unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_en | input | 1 | Read strobe, gates `rdata` |
| addr | input | 4 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational |
| tmo_i | input | N_CH | Timeout pulses from the channels |
| ext_trig_i | input | N_CH | External trigger line per channel |
| dbg_i | input | 1 | Debug-halt request |
| doze_i | input | 1 | Doze request |
| chan_en_o | output | N_CH | Channel run-enable bits |
| chan_run_o | output | 1 | Low freezes every channel |
| chan_rst_o | output | 1 | Soft-reset level to the channels |
| trig_o | output | N_CH | Routed trigger per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
Random cycles mix writes to every address with random timeout pulses and random external trigger levels. Reads in these cycles expose set/clear interplay and the effect of flag clears. Trigger selectors across the full 4-bit range separate the external path, the internal path to an existing channel, and the out-of-range zero. Directed cases aim at what random traffic seldom lines up: a timeout colliding with a clear on the same flag, zero-mask strobes, and freeze combinations. A long soft-reset window with writes aimed at every register shows that only the control word survives.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam int unsigned CH_MAX = 16;
  localparam int unsigned SEL_W  = $clog2(CH_MAX);
  localparam int unsigned AW     = 4;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_STAT  = 4'd1;
  localparam logic [AW-1:0] A_MASK  = 4'd2;
  localparam logic [AW-1:0] A_SET   = 4'd3;
  localparam logic [AW-1:0] A_CLR   = 4'd4;
  localparam logic [AW-1:0] A_TCFG0 = 4'd8;

  localparam int unsigned B_RUN_DBG  = 0;
  localparam int unsigned B_RUN_DOZE = 1;
  localparam int unsigned B_SRST     = 2;
  localparam int unsigned CTRL_W     = 3;
  localparam int unsigned B_TSRC     = 8;

  // Sticky flag update: a new hit outranks a clear on the same bit.
  function automatic logic [CH_MAX-1:0] flag_next(input logic [CH_MAX-1:0] cur,
                                                  input logic [CH_MAX-1:0] hit,
                                                  input logic [CH_MAX-1:0] clr);
    return (cur & ~clr) | hit;
  endfunction

  // Trigger pick: external line, or a sibling timeout, or zero when out of range.
  function automatic logic pick_trig(input logic src, input logic [SEL_W-1:0] sel,
                                     input logic [CH_MAX-1:0] tmo, input logic ext,
                                     input int unsigned n_ch);
    if (!src) return ext;
    if (32'(sel) >= n_ch) return 1'b0;
    return tmo[sel];
  endfunction
endpackage

// File: rtl/tmc_flag_bank.sv
module tmc_flag_bank
  import tmc_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_clr,
  input  logic [N_CH-1:0] hit_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] flags_o
);
  logic [CH_MAX-1:0] nxt_wide;

  always_comb nxt_wide = flag_next(CH_MAX'(flags_o), CH_MAX'(hit_i), CH_MAX'(clr_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_o <= '0;
    else if (hold_clr) flags_o <= '0;
    else               flags_o <= nxt_wide[N_CH-1:0];
  end
endmodule

// File: rtl/tmc_trig_route.sv
module tmc_trig_route
  import tmc_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic [N_CH-1:0]            src_i,
  input  logic [N_CH-1:0][SEL_W-1:0] sel_i,
  input  logic [N_CH-1:0]            tmo_i,
  input  logic [N_CH-1:0]            ext_i,
  output logic [N_CH-1:0]            trig_o
);
  logic [CH_MAX-1:0] tmo_wide;
  assign tmo_wide = CH_MAX'(tmo_i);

  for (genvar g = 0; g < N_CH; g++) begin : g_route
    assign trig_o[g] = pick_trig(src_i[g], sel_i[g], tmo_wide, ext_i[g], N_CH);
  end
endmodule

// File: rtl/timer_ctrl_hub.sv
module timer_ctrl_hub
  import tmc_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [3:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [N_CH-1:0] tmo_i,
  input  logic [N_CH-1:0] ext_trig_i,
  input  logic            dbg_i,
  input  logic            doze_i,
  output logic [N_CH-1:0] chan_en_o,
  output logic            chan_run_o,
  output logic            chan_rst_o,
  output logic [N_CH-1:0] trig_o,
  output logic            irq_o
);
  // Register state
  logic [CTRL_W-1:0]          ctrl_q;
  logic [N_CH-1:0]            en_q;
  logic [N_CH-1:0]            mask_q;
  logic [N_CH-1:0]            flags;
  logic [N_CH-1:0]            tsrc_q;
  logic [N_CH-1:0][SEL_W-1:0] tsel_q;

  // Named internal events
  logic            srst;
  logic            wr_ctrl, wr_stat, wr_mask, wr_set, wr_clr;
  logic [N_CH-1:0] wr_tcfg;
  logic [N_CH-1:0] wmask;
  logic [N_CH-1:0] clr_mask;
  logic            freeze;

  assign srst     = ctrl_q[B_SRST];
  assign wmask    = wdata[N_CH-1:0];
  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_stat  = wr_en && (addr == A_STAT);
  assign wr_mask  = wr_en && (addr == A_MASK);
  assign wr_set   = wr_en && (addr == A_SET);
  assign wr_clr   = wr_en && (addr == A_CLR);
  assign clr_mask = wr_stat ? wmask : '0;

  for (genvar g = 0; g < N_CH; g++) begin : g_tcfg
    assign wr_tcfg[g] = wr_en && (addr == A_TCFG0 + 4'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tsrc_q[g] <= 1'b0;
        tsel_q[g] <= '0;
      end else if (srst) begin
        tsrc_q[g] <= 1'b0;
        tsel_q[g] <= '0;
      end else if (wr_tcfg[g]) begin
        tsrc_q[g] <= wdata[B_TSRC];
        tsel_q[g] <= wdata[SEL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
    end else if (srst) begin
      en_q   <= '0;
      mask_q <= '0;
    end else begin
      if (wr_set)       en_q   <= en_q | wmask;
      else if (wr_clr)  en_q   <= en_q & ~wmask;
      if (wr_mask)      mask_q <= wmask;
    end
  end

  tmc_flag_bank #(.N_CH(N_CH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_clr (srst),
    .hit_i    (tmo_i),
    .clr_i    (clr_mask),
    .flags_o  (flags)
  );

  tmc_trig_route #(.N_CH(N_CH)) u_route (
    .src_i  (tsrc_q),
    .sel_i  (tsel_q),
    .tmo_i  (tmo_i),
    .ext_i  (ext_trig_i),
    .trig_o (trig_o)
  );

  assign freeze     = (dbg_i && !ctrl_q[B_RUN_DBG]) || (doze_i && !ctrl_q[B_RUN_DOZE]);
  assign chan_run_o = !freeze;
  assign chan_rst_o = srst;
  assign chan_en_o  = en_q;
  assign irq_o      = |(flags & mask_q);

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (addr)
      A_CTRL:  rd_val = DW'(ctrl_q);
      A_STAT:  rd_val = DW'(flags);
      A_MASK:  rd_val = DW'(mask_q);
      A_SET:   rd_val = DW'(en_q);
      default: rd_val = '0;
    endcase
    for (int i = 0; i < N_CH; i++) begin
      if (addr == A_TCFG0 + 4'(i))
        rd_val = DW'({tsrc_q[i], 4'b0000, tsel_q[i]});
    end
  end
  assign rdata = rd_en ? rd_val : '0;
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker
  import tmc_pkg::*;
#(
  parameter int N_CH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       srst,
  input logic                       wr_set,
  input logic                       wr_clr,
  input logic                       wr_ctrl,
  input logic [N_CH-1:0]            wmask,
  input logic [N_CH-1:0]            en_q,
  input logic [N_CH-1:0]            mask_q,
  input logic [N_CH-1:0]            flags,
  input logic [N_CH-1:0]            tmo_i,
  input logic                       irq_o,
  input logic [N_CH-1:0]            trig_o,
  input logic [N_CH-1:0]            tsrc_q,
  input logic [N_CH-1:0][SEL_W-1:0] tsel_q,
  input logic                       dbg_i,
  input logic                       doze_i,
  input logic [CTRL_W-1:0]          ctrl_q,
  input logic                       chan_run_o
);
  AST_SET_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !srst) |=> ((en_q & $past(wmask)) == $past(wmask))); // R1
  AST_CLR_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !srst) |=> ((en_q & $past(wmask)) == '0)); // R2
  AST_TIMEOUT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && tmo_i != '0) |=> ((flags & $past(tmo_i)) == $past(tmo_i))); // R4
  AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o); // R5
  AST_SRST_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (en_q == '0 && flags == '0 && mask_q == '0 && !irq_o)); // R6
  AST_SRST_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !wr_ctrl) |=> srst); // R6
  AST_FREEZE_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i && !ctrl_q[B_RUN_DBG]) |-> !chan_run_o); // R9
  AST_FREEZE_DOZE: assert property (@(posedge clk) disable iff (!rst_n)
    (doze_i && !ctrl_q[B_RUN_DOZE]) |-> !chan_run_o); // R9

  for (genvar g = 0; g < N_CH; g++) begin : g_oor
    AST_SEL_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (tsrc_q[g] && int'(tsel_q[g]) >= N_CH) |-> !trig_o[g]); // R8
  end
endmodule

bind timer_ctrl_hub tmc_checker #(.N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srst       (srst),
  .wr_set     (wr_set),
  .wr_clr     (wr_clr),
  .wr_ctrl    (wr_ctrl),
  .wmask      (wmask),
  .en_q       (en_q),
  .mask_q     (mask_q),
  .flags      (flags),
  .tmo_i      (tmo_i),
  .irq_o      (irq_o),
  .trig_o     (trig_o),
  .tsrc_q     (tsrc_q),
  .tsel_q     (tsel_q),
  .dbg_i      (dbg_i),
  .doze_i     (doze_i),
  .ctrl_q     (ctrl_q),
  .chan_run_o (chan_run_o)
);

// File: tb/tb_timer_ctrl_hub.sv
module tb_timer_ctrl_hub;
  localparam int N = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0, re = 1'b0;
  logic [3:0]    ad = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  tmo = '0, ext = '0;
  logic          dbg = 1'b0, doze = 1'b0;
  logic [N-1:0]  chan_en, trig;
  logic          chan_run, chan_rst, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  timer_ctrl_hub #(.N_CH(N), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(we), .rd_en(re), .addr(ad), .wdata(wd),
    .rdata(rdata), .tmo_i(tmo), .ext_trig_i(ext), .dbg_i(dbg), .doze_i(doze),
    .chan_en_o(chan_en), .chan_run_o(chan_run), .chan_rst_o(chan_rst),
    .trig_o(trig), .irq_o(irq)
  );

  // Reference state, kept from the requirements
  logic [2:0]   m_ctrl = '0;
  logic [N-1:0] m_en = '0, m_flag = '0, m_mask = '0, m_src = '0;
  logic [3:0]   m_sel [N];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read();
    logic [31:0] v;
    v = '0;
    if (ad == 4'd0) v = 32'(m_ctrl);
    else if (ad == 4'd1) v = 32'(m_flag);
    else if (ad == 4'd2) v = 32'(m_mask);
    else if (ad == 4'd3) v = 32'(m_en);
    for (int c = 0; c < N; c++)
      if (int'(ad) == 8 + c) v = (32'(m_src[c]) << 8) | 32'(m_sel[c]);
    return re ? v : 32'h0;
  endfunction

  function automatic logic exp_trig(input int c);
    if (!m_src[c]) return ext[c];
    if (int'(m_sel[c]) >= N) return 1'b0;
    return tmo[m_sel[c]];
  endfunction

  task automatic check_outputs();
    chk("R11 read data", rdata, exp_read());
    chk("R5 interrupt", 32'(irq), 32'(|(m_flag & m_mask)));
    chk("R6 soft-reset level", 32'(chan_rst), 32'(m_ctrl[2]));
    chk("R9 run level", 32'(chan_run),
        32'(!((dbg && !m_ctrl[0]) || (doze && !m_ctrl[1]))));
    chk("R1 enables", 32'(chan_en), 32'(m_en));
    for (int c = 0; c < N; c++) begin
      if (m_src[c] && int'(m_sel[c]) >= N) chk("R8 out-of-range trigger", 32'(trig[c]), 32'(exp_trig(c)));
      else chk("R7 trigger route", 32'(trig[c]), 32'(exp_trig(c)));
    end
  endtask

  task automatic model_step();
    logic sr;
    logic [N-1:0] w;
    sr = m_ctrl[2];
    w = wd[N-1:0];
    if (we && ad == 4'd0) m_ctrl = wd[2:0];
    if (sr) begin
      m_en = '0; m_flag = '0; m_mask = '0; m_src = '0;
      for (int c = 0; c < N; c++) m_sel[c] = '0;
    end else begin
      if (we && ad == 4'd3) m_en = m_en | w;
      if (we && ad == 4'd4) m_en = m_en & ~w;
      m_flag = (m_flag & ~((we && ad == 4'd1) ? w : '0)) | tmo;
      if (we && ad == 4'd2) m_mask = w;
      for (int c = 0; c < N; c++)
        if (we && int'(ad) == 8 + c) begin
          m_sel[c] = wd[3:0];
          m_src[c] = wd[8];
        end
    end
  endtask

  // One cycle: inputs already driven after a falling edge
  task automatic cycle();
    #2;
    check_outputs();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic drive(input logic w, input logic r, input logic [3:0] a, input logic [31:0] d,
                       input logic [N-1:0] t, input logic [N-1:0] e, input logic db, input logic dz);
    we = w; re = r; ad = a; wd = d; tmo = t; ext = e; dbg = db; doze = dz;
    cycle();
  endtask

  task automatic idle_read(input logic [3:0] a);
    drive(1'b0, 1'b1, a, 32'h0, '0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    for (int c = 0; c < N; c++) m_sel[c] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state read through every address
    for (int a = 0; a < 16; a++) begin
      idle_read(4'(a));
      chk("R10 reset value", rdata, 32'h0);
    end

    // R1 / R2: set and clear strobes, zero bits have no effect
    drive(1, 0, 4'd3, 32'h5, '0, '0, 0, 0);
    idle_read(4'd3);
    drive(1, 0, 4'd3, 32'h0, '0, '0, 0, 0);
    idle_read(4'd3);
    chk("R1 zero set bits ignored", rdata, 32'h5);
    drive(1, 0, 4'd4, 32'h1, '0, '0, 0, 0);
    drive(1, 0, 4'd4, 32'h0, '0, '0, 0, 0);
    idle_read(4'd3);
    chk("R2 clear one bit", rdata, 32'h4);
    idle_read(4'd4);
    chk("R11 clear address reads zero", rdata, 32'h0);

    // R3 / R4 / R5: flags, collisions, mask
    drive(1, 0, 4'd2, 32'hF, 4'b0010, '0, 0, 0);
    drive(1, 1, 4'd1, 32'h0, '0, '0, 0, 0);
    idle_read(4'd1);
    chk("R3 zero write keeps flag", rdata, 32'h2);
    chk("R5 interrupt with masked flag", 32'(irq), 32'h1);
    drive(1, 0, 4'd1, 32'h2, 4'b0010, '0, 0, 0);
    idle_read(4'd1);
    chk("R4 timeout beats clear", rdata, 32'h2);
    drive(1, 0, 4'd1, 32'h2, '0, '0, 0, 0);
    idle_read(4'd1);
    chk("R3 write one clears", rdata, 32'h0);

    // R7 / R8: routing
    drive(1, 0, 4'd8, 32'h102, '0, '0, 0, 0);
    drive(1, 0, 4'd9, 32'h107, '0, '0, 0, 0);
    drive(0, 0, 4'd0, 32'h0, 4'b0100, 4'b0000, 0, 0);
    drive(0, 0, 4'd0, 32'h0, 4'b1111, 4'b1111, 0, 0);
    drive(1, 0, 4'd9, 32'h10F, 4'b1111, 4'b0000, 0, 0);
    drive(0, 0, 4'd0, 32'h0, 4'b1111, 4'b0000, 0, 0);
    chk("R8 selector 15 gives zero", 32'(trig[1]), 32'h0);

    // R9: freeze combinations
    drive(0, 0, 4'd0, 32'h0, '0, '0, 1, 0);
    chk("R9 debug freezes", 32'(chan_run), 32'h0);
    drive(1, 0, 4'd0, 32'h1, '0, '0, 1, 1);
    drive(0, 0, 4'd0, 32'h0, '0, '0, 1, 1);
    chk("R9 doze still freezes", 32'(chan_run), 32'h0);
    drive(1, 0, 4'd0, 32'h3, '0, '0, 1, 1);
    drive(0, 0, 4'd0, 32'h0, '0, '0, 1, 1);
    chk("R9 both allowed to run", 32'(chan_run), 32'h1);

    // R6: soft-reset window, writes everywhere ignored, control kept
    drive(1, 0, 4'd3, 32'hF, 4'b1111, '0, 0, 0);
    drive(1, 0, 4'd0, 32'h6, '0, '0, 0, 0);
    drive(1, 0, 4'd3, 32'hF, 4'b1111, '0, 0, 0);
    drive(1, 0, 4'd2, 32'hF, 4'b1111, '0, 0, 0);
    drive(1, 0, 4'd10, 32'h101, 4'b1111, '0, 0, 0);
    idle_read(4'd1);
    chk("R6 flags held zero", rdata, 32'h0);
    idle_read(4'd0);
    chk("R6 control kept", rdata, 32'h6);
    chk("R6 enables held zero", 32'(chan_en), 32'h0);
    drive(1, 0, 4'd0, 32'h0, '0, '0, 0, 0);

    // Random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] a;
      logic [31:0] d;
      a = 4'($urandom_range(0, 12));
      d = $urandom;
      if (a == 4'd0) d = {29'b0, ($urandom_range(0, 15) == 0), d[1:0]};
      else if (a >= 4'd8) d = d & 32'h10F;
      drive(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 1)), a, d,
            N'($urandom) & N'($urandom), N'($urandom),
            1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R1..all requirements): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule